// File: doc/BRIEF.md
# Latched-Input Parallel-to-Serial Shift Register

This block turns a parallel word into a serial bit stream in two stages. A holding register captures the parallel input word on a rising edge of a storage strobe. A separate shift register of the same width delivers its top bit on the serial output. The shift register can be loaded from the holding register, forced to zero, or advanced one place on a rising edge of a shift strobe, with a fresh bit entering at stage 0. The holding register is decoupled from the shifter, so the next word can be captured while the current one is still being shifted out.

All strobes and the parallel word come from outside the block's clock domain. Each one passes through a synchronizer chain clocked by the system clock. Rising edges of the two strobes are then found by comparing each synchronized level with its value one cycle earlier. Load and clear are level controls. While the active-low load is held, the shifter follows the holding register and ignores the shift strobe. A storage edge that arrives during load flows the new word straight into the shifter. Clear asserted together with load is an illegal combination. In that case clear wins and a sticky fault flag is raised, which only the synchronous reset removes.

Top module: `latched_piso`

## Requirements
- R1: A synchronous active-high reset clears the holding register, the shift register and the fault flag, so `ser_out` and `bad_ctrl` read 0 afterwards.
- R2: A rising edge of `stor_clk` while `load_n` is high captures `par_in` into the holding register and leaves the shift register and `ser_out` unchanged.
- R3: A rising edge of `shift_clk` while `load_n` and `clear_n` are both high moves every shift stage up by one place (stage i takes stage i-1). Stage 0 takes `ser_in`, and `ser_out` is stage W-1, so a loaded word leaves most significant bit first.
- R4: While `load_n` is low and `clear_n` is high, the shift register equals the holding register, and `shift_clk` edges have no effect.
- R5: A rising edge of `stor_clk` while `load_n` is low puts the new `par_in` word into both the holding register and the shift register.
- R6: While `clear_n` is low, the shift register is zero and `shift_clk` edges have no effect.
- R7: When `load_n` and `clear_n` are low together, the shift register is zero and `bad_ctrl` goes to 1. It stays at 1 after the controls are released and returns to 0 only on reset.
- R8: A word captured into the holding register while the previous word is still shifting out does not disturb that word. After the next load, the new word appears intact on `ser_out`, most significant bit first.
- R9: With the default of two synchronizer stages, a change of a strobe or level input made between clock edges appears at the outputs after the third following rising edge of `clk` and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| par_in | input | W | Parallel data word |
| stor_clk | input | 1 | Storage strobe; its rising edge captures `par_in` |
| shift_clk | input | 1 | Shift strobe; its rising edge advances the shifter |
| load_n | input | 1 | Level load from holding register, active low |
| clear_n | input | 1 | Level clear of the shifter, active low |
| ser_in | input | 1 | Serial bit entering stage 0 |
| ser_out | output | 1 | Top stage of the shift register |
| bad_ctrl | output | 1 | Sticky flag for load and clear active together |

## Verification
Every external input crosses two synchronizer flops before it is used, and the edge detector adds no register of its own, so the holding and shift registers change on the third rising clock edge after an input moves. R9 is checked directly: the bench samples `ser_out` on the falling edges after the first, second and third rising edges and expects the change only at the third. All other stimulus is applied on a falling edge and held for four full cycles before the outputs are sampled on a falling edge, which leaves one cycle of margin beyond the due cycle. Strobes are then dropped and held low for another four cycles, so each pulse produces exactly one detected edge.

// File: rtl/lpiso_pkg.sv
package lpiso_pkg;

    // Synchronized control strobes, bundled so one synchronizer covers them.
    typedef struct packed {
        logic stor;
        logic shift;
        logic load_n;
        logic clear_n;
        logic ser;
    } ctrl_t;

    // Inactive levels used as the synchronizer reset value, so that no
    // spurious edge or load appears when reset is released.
    localparam ctrl_t CTRL_IDLE = '{stor: 1'b0, shift: 1'b0, load_n: 1'b1,
                                    clear_n: 1'b1, ser: 1'b0};

endpackage

// File: rtl/lpiso_sync.sv
module lpiso_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] pipe_d [STAGES];
    logic [W-1:0] pipe_q [STAGES];

    always_comb begin
        pipe_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) begin
                pipe_q[i] <= RST_VAL;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                pipe_q[i] <= pipe_d[i];
            end
        end
    end

    assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/lpiso_edge.sv
module lpiso_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);

    logic [N-1:0] prev_d;
    logic [N-1:0] prev_q;

    always_comb begin
        prev_d = lvl;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= prev_d;
    end

    // One rising-edge detector per strobe.
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_rise
            assign rise[g] = lvl[g] & ~prev_q[g];
        end
    endgenerate

endmodule

// File: rtl/lpiso_store.sv
module lpiso_store #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);

    logic [W-1:0] hold_d;
    logic [W-1:0] hold_q;

    always_comb begin
        hold_d = hold_q;
        if (cap) hold_d = din;
    end

    always_ff @(posedge clk) begin
        if (rst) hold_q <= '0;
        else     hold_q <= hold_d;
    end

    assign q = hold_q;

endmodule

// File: rtl/lpiso_shift.sv
module lpiso_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         clr,
    input  logic         flow,
    input  logic         step,
    input  logic         ser,
    input  logic [W-1:0] par_new,
    input  logic [W-1:0] stor_q,
    output logic [W-1:0] q,
    output logic         err
);

    typedef struct packed {
        logic [W-1:0] sreg;
        logic         err;
    } state_t;

    state_t st_d;
    state_t st_q;

    // Priority: clear, then load (with flow-through), then shift.
    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.sreg = '0;
            if (load) st_d.err = 1'b1;
        end else if (load) begin
            st_d.sreg = flow ? par_new : stor_q;
        end else if (step) begin
            st_d.sreg = {st_q.sreg[W-2:0], ser};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign q   = st_q.sreg;
    assign err = st_q.err;

endmodule

// File: rtl/latched_piso.sv
module latched_piso
    import lpiso_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] par_in,
    input  logic         stor_clk,
    input  logic         shift_clk,
    input  logic         load_n,
    input  logic         clear_n,
    input  logic         ser_in,
    output logic         ser_out,
    output logic         bad_ctrl
);

    localparam int CW = $bits(ctrl_t);

    ctrl_t        ctrl_raw;
    ctrl_t        ctrl_s;
    logic [W-1:0] par_s;
    logic [1:0]   rise;
    logic         stor_rise;
    logic         shift_rise;
    logic         load_act;
    logic         clr_act;
    logic [W-1:0] stor_q;
    logic [W-1:0] sreg;

    always_comb begin
        ctrl_raw.stor    = stor_clk;
        ctrl_raw.shift   = shift_clk;
        ctrl_raw.load_n  = load_n;
        ctrl_raw.clear_n = clear_n;
        ctrl_raw.ser     = ser_in;
    end

    lpiso_sync #(.W(CW), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_IDLE)) u_sync_ctrl (
        .clk (clk),
        .rst (rst),
        .d   (ctrl_raw),
        .q   (ctrl_s)
    );

    lpiso_sync #(.W(W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_data (
        .clk (clk),
        .rst (rst),
        .d   (par_in),
        .q   (par_s)
    );

    lpiso_edge #(.N(2)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  ({ctrl_s.stor, ctrl_s.shift}),
        .rise (rise)
    );

    assign stor_rise  = rise[1];
    assign shift_rise = rise[0];
    assign load_act   = ~ctrl_s.load_n;
    assign clr_act    = ~ctrl_s.clear_n;

    lpiso_store #(.W(W)) u_store (
        .clk (clk),
        .rst (rst),
        .cap (stor_rise),
        .din (par_s),
        .q   (stor_q)
    );

    lpiso_shift #(.W(W)) u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (load_act),
        .clr     (clr_act),
        .flow    (stor_rise),
        .step    (shift_rise),
        .ser     (ctrl_s.ser),
        .par_new (par_s),
        .stor_q  (stor_q),
        .q       (sreg),
        .err     (bad_ctrl)
    );

    assign ser_out = sreg[W-1];

endmodule

// File: rtl/latched_piso_chk.sv
module latched_piso_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] sreg,
    input logic [W-1:0] stor_q,
    input logic         load_act,
    input logic         clr_act,
    input logic         shift_rise,
    input logic         stor_rise,
    input logic         ser_s,
    input logic         bad_ctrl
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (sreg == '0) && (stor_q == '0) && !bad_ctrl);

    // R2
    stor_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !stor_rise |=> $stable(stor_q));

    // R2
    shift_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr_act && !load_act && !shift_rise) |=> $stable(sreg));

    // R3
    shift_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr_act && !load_act && shift_rise)
        |=> sreg == {$past(sreg[W-2:0]), $past(ser_s)});

    // R4
    load_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (load_act && !clr_act) |=> sreg == stor_q);

    // R6
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        clr_act |=> sreg == '0);

    // R7
    fault_set_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_act && load_act) |=> bad_ctrl);

    // R7
    fault_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        bad_ctrl |=> bad_ctrl);

endmodule

bind latched_piso latched_piso_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sreg       (sreg),
    .stor_q     (stor_q),
    .load_act   (load_act),
    .clr_act    (clr_act),
    .shift_rise (shift_rise),
    .stor_rise  (stor_rise),
    .ser_s      (ctrl_s.ser),
    .bad_ctrl   (bad_ctrl)
);

// File: tb/latched_piso_tb.sv
module latched_piso_tb;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] par_in = '0;
    logic         stor_clk = 1'b0;
    logic         shift_clk = 1'b0;
    logic         load_n = 1'b1;
    logic         clear_n = 1'b1;
    logic         ser_in = 1'b0;
    logic         ser_out;
    logic         bad_ctrl;

    int n_run  = 0;
    int n_fail = 0;

    // Reference state, derived from the requirements.
    logic [W-1:0] m_stor = '0;
    logic [W-1:0] m_sreg = '0;
    logic         m_flag = 1'b0;

    always #5 clk = ~clk;

    latched_piso #(.W(W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .par_in    (par_in),
        .stor_clk  (stor_clk),
        .shift_clk (shift_clk),
        .load_n    (load_n),
        .clear_n   (clear_n),
        .ser_in    (ser_in),
        .ser_out   (ser_out),
        .bad_ctrl  (bad_ctrl)
    );

    // Stimulus table: op 0 capture, 1 shift, 2 load level, 3 clear level.
    typedef struct packed {
        logic [1:0]   op;
        logic [W-1:0] val;
    } step_t;

    localparam int NSTEP = 26;
    localparam step_t STEPS [NSTEP] = '{
        '{2'd0, 8'hA5}, '{2'd2, 8'h00}, '{2'd2, 8'h01},
        '{2'd1, 8'h01}, '{2'd1, 8'h00},
        '{2'd0, 8'h3C},
        '{2'd1, 8'h01}, '{2'd1, 8'h00}, '{2'd1, 8'h01},
        '{2'd1, 8'h01}, '{2'd1, 8'h00}, '{2'd1, 8'h00},
        '{2'd2, 8'h00}, '{2'd2, 8'h01},
        '{2'd1, 8'h00}, '{2'd1, 8'h00}, '{2'd1, 8'h00}, '{2'd1, 8'h00},
        '{2'd1, 8'h00}, '{2'd1, 8'h00}, '{2'd1, 8'h00}, '{2'd1, 8'h00},
        '{2'd0, 8'h81}, '{2'd3, 8'h00}, '{2'd3, 8'h01}, '{2'd1, 8'h01}
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic settle();
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_all(input string req);
        check(req, ser_out, m_sreg[W-1]);
        check(req, bad_ctrl, m_flag);
    endtask

    task automatic apply_levels();
        if (!clear_n) begin
            m_sreg = '0;
            if (!load_n) m_flag = 1'b1;
        end else if (!load_n) begin
            m_sreg = m_stor;
        end
    endtask

    task automatic do_cap(input logic [W-1:0] d, input string req);
        @(negedge clk);
        par_in = d;
        stor_clk = 1'b1;
        settle();
        m_stor = d;
        if (!clear_n) m_sreg = '0;
        else if (!load_n) m_sreg = d;
        check_all(req);
        stor_clk = 1'b0;
        settle();
    endtask

    task automatic do_shift(input logic b, input string req);
        @(negedge clk);
        ser_in = b;
        shift_clk = 1'b1;
        settle();
        if (clear_n && load_n) m_sreg = {m_sreg[W-2:0], b};
        check_all(req);
        shift_clk = 1'b0;
        settle();
    endtask

    task automatic set_load(input logic v, input string req);
        @(negedge clk);
        load_n = v;
        settle();
        apply_levels();
        check_all(req);
    endtask

    task automatic set_clear(input logic v, input string req);
        @(negedge clk);
        clear_n = v;
        settle();
        apply_levels();
        check_all(req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        stor_clk = 1'b0; shift_clk = 1'b0; load_n = 1'b1; clear_n = 1'b1;
        ser_in = 1'b0; par_in = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_stor = '0; m_sreg = '0; m_flag = 1'b0;
        settle();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        // R1: reset state
        do_reset();
        check_all("R1 reset");

        // Table walk: R2 captures, R3 shifts, R4 loads, R6 clears,
        // R8 word captured mid-shift then loaded and shifted out.
        for (int i = 0; i < NSTEP; i++) begin
            case (STEPS[i].op)
                2'd0: do_cap(STEPS[i].val, "R2/R8 table capture");
                2'd1: do_shift(STEPS[i].val[0], "R3/R8 table shift");
                2'd2: set_load(STEPS[i].val[0], "R4 table load");
                default: set_clear(STEPS[i].val[0], "R6 table clear");
            endcase
        end

        // R2: capture with load high leaves ser_out alone
        do_cap(8'h00, "R2 capture no disturb");
        do_cap(8'h80, "R2 capture no disturb");

        // R4: shift edges ignored while load held low
        set_load(1'b0, "R4 load");
        do_shift(1'b0, "R4 shift ignored under load");
        do_shift(1'b0, "R4 shift ignored under load");

        // R5: flow-through capture while load low
        do_cap(8'h00, "R5 flow-through");
        do_cap(8'hFF, "R5 flow-through");
        do_cap(8'h40, "R5 flow-through");
        set_load(1'b1, "R4 load release");

        // R9: shift result due on the third rising edge
        @(negedge clk);
        ser_in = 1'b0;
        shift_clk = 1'b1;
        @(negedge clk);
        check("R9 after edge 1", ser_out, 1'b0);
        @(negedge clk);
        check("R9 after edge 2", ser_out, 1'b0);
        @(negedge clk);
        check("R9 after edge 3", ser_out, 1'b1);
        m_sreg = {m_sreg[W-2:0], 1'b0};
        settle();
        shift_clk = 1'b0;
        settle();
        check_all("R9 settled");

        // R6: clear zeroes and blocks shifting
        set_clear(1'b0, "R6 clear");
        for (int k = 0; k < W; k++) do_shift(1'b1, "R6 shift ignored under clear");
        set_clear(1'b1, "R6 clear release");
        do_shift(1'b1, "R3 shift after clear");

        // R7: illegal combination, sticky until reset
        set_load(1'b0, "R7 load first");
        set_clear(1'b0, "R7 both low");
        set_clear(1'b1, "R7 sticky");
        set_load(1'b1, "R7 sticky");
        do_shift(1'b1, "R7 sticky");
        do_reset();
        check_all("R1 reset clears fault");

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule